// File: doc/BRIEF.md
# Adapter Board Control, Status and Parity Capture Register

This block holds the host-visible control/status word of a network adapter board and the two registers that describe the most recent memory parity fault. The host writes the status word to hold the board in reset, take it off loopback, raise attention toward the network controller, select the P2 bus and the RAM size, and enable the two interrupt sources. The host reads the same word to see the controller interrupt flag and the parity-error flag.

When the memory side reports a parity error, the block records the full 20-bit failing address, which byte lane failed and which bus master was active. It keeps that record, frozen, until the host writes the acknowledge bit in the parity control register. A single level interrupt output combines both flags with their enables. Attention reaches the controller as a one-cycle pulse.

Top module: `adapter_csr`

## Requirements
- R1: After `rst_n` is low, `stat_rd`, `pctl_rd`, `paddr_lo`, `irq` and `attn_pulse` are all zero.
- R2: A write with `wr_sel`=0 stores bits 15 (board reset), 14 (on-air), 13 (attention), 12 (interrupt enable), 11 (parity interrupt enable), 5 (P2 enable), 4 (256 KB RAM) and 3:0 (high address); they read back in place and drive `board_rst`, `on_air`, `p2_en`, `ram_256k`, `hi_addr` from the next cycle.
- R3: `attn_pulse` is high for exactly the one cycle after a write that changes status bit 13 from 0 to 1; rewriting 1 gives no pulse.
- R4: `ctrl_irq` sets status bit 8 (interrupt flag); a status write with bit 8 = 1 clears it; a set in the same cycle wins.
- R5: `par_err` while status bit 9 is clear sets bit 9 and captures the address: bits 15:0 on `paddr_lo`, bits 19:16 on `pctl_rd` bits 3:0, the byte lane on `pctl_rd` bit 6, the source master on `pctl_rd` bit 7; visible the next cycle.
- R6: While status bit 9 is set, further `par_err` pulses leave the captured address, lane and source unchanged.
- R7: A write with `wr_sel`=1 and bit 8 = 1 clears status bit 9; `pctl_rd` bit 8 always reads 0; a `par_err` in the same cycle as the acknowledge is captured and sets bit 9 again.
- R8: `irq` = (bit 8 AND bit 12) OR (bit 9 AND bit 11) of the status word.
- R9: While status bit 15 is set, both flags and all captured fields read zero and `ctrl_irq`/`par_err` are ignored.
- R10: Status bits 10, 9, 7 and 6 cannot be set by a status write; bits 10, 7, 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 0 = status word, 1 = parity control |
| wr_data | input | 16 | Host write data |
| ctrl_irq | input | 1 | Interrupt request from the controller |
| par_err | input | 1 | Parity error strobe from memory |
| par_addr | input | 20 | Failing address |
| par_lane | input | 1 | Failing byte lane |
| par_src | input | 1 | Master active at the error |
| stat_rd | output | 16 | Status word readback |
| pctl_rd | output | 16 | Parity control readback |
| paddr_lo | output | 16 | Low 16 bits of captured address |
| board_rst | output | 1 | Board reset control |
| on_air | output | 1 | Out of loopback |
| attn_pulse | output | 1 | One-cycle attention to controller |
| p2_en | output | 1 | P2 bus enable |
| ram_256k | output | 1 | 256 KB RAM select |
| hi_addr | output | 4 | High address bits 17-20 |
| irq | output | 1 | Interrupt output |

## Verification
Every register result (control bits, flags, captured fields) is due one clock after the edge that takes the write or strobe, and `irq` and `attn_pulse` follow combinationally from those registers in that same cycle. The bench drives each stimulus on a falling edge, pushes the expected readback into a queue at once, and the monitor pops and compares it 2 ns after the next rising edge, so each expectation meets exactly the cycle its result becomes valid. A reset bit written in one cycle clears the flags one cycle later, and the expectations model that extra edge.

// File: rtl/adapter_csr.sv
module adapter_csr #(
  parameter int LO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [15:0]     wr_data,
  input  logic            ctrl_irq,
  input  logic            par_err,
  input  logic [LO_W+3:0] par_addr,
  input  logic            par_lane,
  input  logic            par_src,
  output logic [15:0]     stat_rd,
  output logic [15:0]     pctl_rd,
  output logic [LO_W-1:0] paddr_lo,
  output logic            board_rst,
  output logic            on_air,
  output logic            attn_pulse,
  output logic            p2_en,
  output logic            ram_256k,
  output logic [3:0]      hi_addr,
  output logic            irq
);
  localparam int AW = LO_W + 4;

  logic          attn_q, attn_d, ien_q, pien_q;
  logic          intf_q, perr_q, lane_q, src_q;
  logic [AW-1:0] cap_q;

  wire stat_wr = wr_en && !wr_sel;
  wire ack     = wr_en && wr_sel && wr_data[8];
  wire take    = par_err && (!perr_q || ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {board_rst, on_air, attn_q, ien_q, pien_q, p2_en, ram_256k} <= '0;
      hi_addr <= '0;
      attn_d  <= 1'b0;
    end else begin
      attn_d <= attn_q;
      if (stat_wr) begin
        {board_rst, on_air, attn_q, ien_q, pien_q} <= wr_data[15:11];
        {p2_en, ram_256k} <= wr_data[5:4];
        hi_addr <= wr_data[3:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || board_rst) begin
      intf_q <= 1'b0;
      perr_q <= 1'b0;
      cap_q  <= '0;
      lane_q <= 1'b0;
      src_q  <= 1'b0;
    end else begin
      if (ctrl_irq)                    intf_q <= 1'b1;
      else if (stat_wr && wr_data[8])  intf_q <= 1'b0;
      if (take) begin
        perr_q <= 1'b1;
        cap_q  <= par_addr;
        lane_q <= par_lane;
        src_q  <= par_src;
      end else if (ack) begin
        perr_q <= 1'b0;
      end
    end
  end

  assign attn_pulse = attn_q && !attn_d;
  assign irq        = (intf_q && ien_q) || (perr_q && pien_q);
  assign stat_rd    = {board_rst, on_air, attn_q, ien_q, pien_q, 1'b0, perr_q, intf_q,
                       2'b00, p2_en, ram_256k, hi_addr};
  assign pctl_rd    = {8'h00, src_q, lane_q, 2'b00, cap_q[AW-1:LO_W]};
  assign paddr_lo   = cap_q[LO_W-1:0];

  // R3
  attn_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attn_pulse |=> !attn_pulse);
  // R4
  intf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_irq && !board_rst) |=> stat_rd[8]);
  // R5
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !stat_rd[9] && !board_rst) |=> (stat_rd[9] && paddr_lo == $past(par_addr[LO_W-1:0])));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd[9] && !ack && !board_rst) |=> ($stable(paddr_lo) && $stable(pctl_rd)));
  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !par_err) |=> !stat_rd[9]);
  // R9
  reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst |=> (stat_rd[9:8] == 2'b00 && paddr_lo == '0));
  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd[10] == 1'b0 && stat_rd[7:6] == 2'b00 && pctl_rd[8] == 1'b0);
endmodule

// File: tb/adapter_csr_bench.sv
module adapter_csr_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 0, wr_sel = 0, ctrl_irq = 0, par_err = 0, par_lane = 0, par_src = 0;
  logic [15:0] wr_data = '0;
  logic [19:0] par_addr = '0;
  logic [15:0] stat_rd, pctl_rd, paddr_lo;
  logic        board_rst, on_air, attn_pulse, p2_en, ram_256k, irq;
  logic [3:0]  hi_addr;

  always #4 clk = ~clk;

  adapter_csr u_adapter_csr (.*);

  typedef struct {
    logic [15:0] st, pc, pa;
    logic        irq, attn;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_ctl = '0;
  logic m_intf = 0, m_perr = 0, m_lane = 0, m_src = 0, m_attn = 0;
  logic [19:0] m_addr = '0;

  task automatic cyc(input logic we, input logic sel, input logic [15:0] d,
                     input logic ci, input logic pe, input logic [19:0] a,
                     input logic ln, input logic sr, input string tag);
    logic old_rst, old_attn, ack;
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; ctrl_irq = ci;
    par_err = pe; par_addr = a; par_lane = ln; par_src = sr;
    old_rst = m_ctl[15]; old_attn = m_ctl[13];
    ack = we && sel && d[8];
    if (we && !sel) m_ctl = d & 16'hF83F;
    if (old_rst) begin
      m_intf = 0; m_perr = 0; m_addr = '0; m_lane = 0; m_src = 0;
    end else begin
      if (ci) m_intf = 1;
      else if (we && !sel && d[8]) m_intf = 0;
      if (pe && (!m_perr || ack)) begin
        m_perr = 1; m_addr = a; m_lane = ln; m_src = sr;
      end else if (ack) m_perr = 0;
    end
    e.st = m_ctl | {6'b0, m_perr, m_intf, 8'b0};
    e.pc = {8'h00, m_src, m_lane, 2'b00, m_addr[19:16]};
    e.pa = m_addr[15:0];
    e.irq = (m_intf && m_ctl[12]) || (m_perr && m_ctl[11]);
    e.attn = m_ctl[13] && !old_attn;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 16'h0, 0, 0, 20'h0, 0, 0, tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (stat_rd !== e.st || pctl_rd !== e.pc || paddr_lo !== e.pa ||
            irq !== e.irq || attn_pulse !== e.attn ||
            board_rst !== e.st[15] || on_air !== e.st[14] || p2_en !== e.st[5] ||
            ram_256k !== e.st[4] || hi_addr !== e.st[3:0]) begin
          fails++;
          $display("FAIL %s: st=%h pc=%h pa=%h irq=%b attn=%b expected st=%h pc=%h pa=%h irq=%b attn=%b",
                   e.tag, stat_rd, pctl_rd, paddr_lo, irq, attn_pulse,
                   e.st, e.pc, e.pa, e.irq, e.attn);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: expected=done actual=hung");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    cyc(1, 0, 16'h5835, 0, 0, 20'h0, 0, 0, "R2 control write");
    cyc(1, 0, 16'h5EF5, 0, 0, 20'h0, 0, 0, "R10 reserved and flag bits");
    cyc(1, 0, 16'h7835, 0, 0, 20'h0, 0, 0, "R3 attention rise");
    idle("R3 pulse ends");
    cyc(1, 0, 16'h7835, 0, 0, 20'h0, 0, 0, "R3 no pulse on rewrite");
    cyc(0, 0, 16'h0, 1, 0, 20'h0, 0, 0, "R4 R8 interrupt flag set");
    cyc(1, 0, 16'h5935, 0, 0, 20'h0, 0, 0, "R4 w1c clears flag");
    cyc(1, 0, 16'h5935, 1, 0, 20'h0, 0, 0, "R4 set beats clear");
    cyc(1, 0, 16'h4935, 0, 0, 20'h0, 0, 0, "R8 irq gated by enable");
    cyc(0, 0, 16'h0, 0, 1, 20'hA1234, 1, 0, "R5 R8 parity capture");
    cyc(0, 0, 16'h0, 0, 1, 20'h5BEEF, 0, 1, "R6 second error held");
    cyc(1, 1, 16'h0100, 0, 0, 20'h0, 0, 0, "R7 ack clears flag");
    cyc(0, 0, 16'h0, 0, 1, 20'h3C0DE, 0, 1, "R5 capture src bit");
    cyc(1, 1, 16'h0100, 0, 1, 20'hF00F1, 1, 1, "R7 error with ack captured");
    cyc(1, 1, 16'h00FF, 0, 0, 20'h0, 0, 0, "R7 write without ack bit");
    cyc(1, 0, 16'h0035, 0, 0, 20'h0, 0, 0, "R8 enables off");
    cyc(1, 0, 16'hC835, 0, 0, 20'h0, 0, 0, "R9 reset bit set");
    cyc(0, 0, 16'h0, 1, 1, 20'h12345, 1, 1, "R9 flags cleared");
    cyc(0, 0, 16'h0, 1, 1, 20'h54321, 1, 1, "R9 inputs ignored");
    cyc(1, 0, 16'h1835, 0, 0, 20'h0, 0, 0, "R9 reset bit cleared");
    cyc(0, 0, 16'h0, 0, 1, 20'h0ABCD, 0, 0, "R5 capture after reset");
    idle("R1 final idle");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule